// File: doc/BRIEF.md
# Single-Slot Reconfiguration Controller with Prefetch

This block sits between an in-order host and a coprocessor that holds exactly one configuration at a time. The host sends two kinds of request, each tagged with a configuration number. An execute request asks for an operation on a given configuration. A prefetch request is a hint to start loading a configuration early. The block tracks which configuration occupies the slot and whether that configuration is complete or still loading. It models the load as a countdown of a programmable number of cycles. While an execute request waits for its configuration, the block holds the host off with a stall signal.

A prefetch never stalls the host. It either starts a fresh load or is absorbed when it names the configuration already in the slot. When an execute arrives during a load of the same configuration, it waits only for the cycles still outstanding. When it arrives during a load of some other configuration, the partial load is thrown away and the full latency is paid. Two saturating counters report the cost of reconfiguration: the cycles spent stalled and the number of prefetch requests accepted.

Top module: `reconf_prefetch_ctrl`

## Requirements
- R1: After reset no configuration is valid, `stall` and `op_done` are low, `req_ready` is high and both counters read zero. The first execute request after reset, for any number including 0, therefore stalls for the full latency.
- R2: An execute request whose configuration is complete in the slot raises `op_done` with `op_cfg` equal to its number in the cycle after acceptance, with no stall.
- R3: An execute request whose configuration is neither resident nor loading replaces the slot content. It holds `stall` high for exactly L cycles and raises `op_done` in the cycle after `stall` falls.
- R4: A loaded configuration stays in the slot across any number of executions; repeated executes of it never stall.
- R5: A prefetch (`req_is_prefetch` = 1) naming the configuration that is resident or loading has no effect on the slot or on the load countdown.
- R6: A prefetch naming a different configuration starts a full load at once. `stall` stays low and `req_ready` stays high.
- R7: An execute accepted k cycles after acceptance of a load of the same configuration stalls for max(0, L − k) cycles.
- R8: An execute (`req_is_prefetch` = 0) that names a configuration other than the one being loaded discards the partial load and stalls for the full L cycles.
- R9: L is taken from `load_latency` at the cycle a load starts; later changes do not affect that load. A value of 0 is treated as 1.
- R10: `req_ready` is the inverse of `stall`. A request presented while stalled is not accepted and changes neither the slot nor the counters.
- R11: `stall_cycles` counts the cycles with `stall` high and `prefetch_issues` counts accepted prefetches. Both saturate at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_latency | input | LAT_W | Load time L in cycles, sampled when a load starts |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_is_prefetch | input | 1 | 1 = prefetch hint, 0 = execute |
| req_cfg | input | ID_W | Configuration number of the request |
| stall | output | 1 | Host held off while an execute waits for its configuration |
| op_done | output | 1 | One-cycle pulse: an execute proceeds |
| op_cfg | output | ID_W | Configuration number of the proceeding execute |
| stall_cycles | output | CNT_W | Saturating count of stalled cycles |
| prefetch_issues | output | CNT_W | Saturating count of accepted prefetches |

## Verification
The bench goes after the exact stall length when an execute meets a load of its own configuration at several distances. These include one cycle before the load ends, exactly at its end and well after it. A design off by one in its countdown would give stalls one cycle long or short, or a spurious one-cycle stall. A second prefetch of a loading configuration is checked through the stall of the following execute: a design that restarts the load would stall for nearly L instead of the remainder. The bench also covers configuration 0 right after reset, where a design lacking a valid flag would report a hit. It holds a prefetch on the request lines during a stall, where a design that accepted it would evict the awaited configuration. It changes the latency in the middle of a load and checks both counters at saturation.

// File: rtl/rpc_pkg.sv
// Shared types for the reconfiguration controller.
package rpc_pkg;

    // Request kind as carried on req_is_prefetch.
    typedef enum logic {
        REQ_EXEC     = 1'b0,
        REQ_PREFETCH = 1'b1
    } req_kind_e;

endpackage

// File: rtl/rpc_sat_counter.sv
// Saturating event counter.
// Adds one for every cycle inc is high and holds at the all-ones value.
// Assumes a synchronous active-low reset clears it.
module rpc_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Count events until the top value is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != MAXV)) begin
            count <= count + W'(1);
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV) |=> (count == MAXV)); // R11

    AST_SAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (count != MAXV)) |=> (count == $past(count) + W'(1))); // R11

endmodule

// File: rtl/rpc_slot_tracker.sv
// Configuration slot tracker.
// Holds the number of the configuration that occupies the single slot, a
// valid flag and the cycles left on its load. Any accepted request naming a
// configuration other than the slot's (or any request while the slot is
// empty) discards the slot content and starts a full load. A request naming
// the slot's configuration leaves the countdown running.
// Assumes take is only high when the request is really accepted.
module rpc_slot_tracker #(
    parameter int ID_W  = 4,
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] lat,
    input  logic             take,
    input  logic [ID_W-1:0]  take_id,
    output logic             slot_valid,
    output logic [ID_W-1:0]  slot_id,
    output logic             match,
    output logic             idle,
    output logic             last
);
    logic [LAT_W-1:0] remain;
    logic [LAT_W-1:0] eff_lat;
    logic             start;

    // Latency of a new load; zero is raised to one cycle.
    always_comb begin
        eff_lat = (lat == '0) ? LAT_W'(1) : lat;
    end

    // Hit detection and load-start decision for the accepted request.
    always_comb begin
        match = slot_valid && (slot_id == take_id);
        start = take && !match;
        idle  = (remain == '0);
        last  = (remain == LAT_W'(1));
    end

    // Slot contents and load countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= 1'b0;
            slot_id    <= '0;
            remain     <= '0;
        end else if (start) begin
            slot_valid <= 1'b1;
            slot_id    <= take_id;
            remain     <= eff_lat;
        end else if (!idle) begin
            remain     <= remain - LAT_W'(1);
        end
    end

    AST_HIT_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && match) |=> (slot_valid && (slot_id == $past(slot_id)))); // R5

    AST_MISS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !match) |=> (!idle && (slot_id == $past(take_id)))); // R3

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !take) |=> (remain == $past(remain) - LAT_W'(1))); // R9

endmodule

// File: rtl/rpc_host_gate.sv
// Host-side gate for execute requests.
// Lets an execute proceed at once when its configuration is complete, or will
// be complete at the same edge. Otherwise holds the host with stall until
// the slot tracker signals the last load cycle, then releases the execute.
// Assumes no request is accepted while stall is high.
module rpc_host_gate #(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_exec,
    input  logic [ID_W-1:0] take_id,
    input  logic            match,
    input  logic            idle,
    input  logic            last,
    output logic            stall,
    output logic            done,
    output logic [ID_W-1:0] done_id
);
    logic waiting;

    // Track a waiting execute and pulse done when it may proceed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting <= 1'b0;
            done    <= 1'b0;
            done_id <= '0;
        end else if (take_exec) begin
            done_id <= take_id;
            if (match && (idle || last)) begin
                waiting <= 1'b0;
                done    <= 1'b1;
            end else begin
                waiting <= 1'b1;
                done    <= 1'b0;
            end
        end else if (waiting && last) begin
            waiting <= 1'b0;
            done    <= 1'b1;
        end else begin
            done    <= 1'b0;
        end
    end

    // Stall is the waiting state itself.
    always_comb begin
        stall = waiting;
    end

    AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && last) |=> (!stall && done)); // R7

    AST_HIT_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exec && match && idle) |=> (done && !stall)); // R2

endmodule

// File: rtl/reconf_prefetch_ctrl.sv
// Reconfiguration controller with prefetch for a single-slot coprocessor.
// Accepts execute and prefetch requests from the host one per cycle, keeps
// the slot state, stalls the host while an execute waits for its
// configuration and counts overhead cycles.
// Assumes the host holds a request stable while req_valid is high and
// req_ready is low.
module reconf_prefetch_ctrl #(
    parameter int ID_W  = 4,
    parameter int LAT_W = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] load_latency,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_is_prefetch,
    input  logic [ID_W-1:0]  req_cfg,
    output logic             stall,
    output logic             op_done,
    output logic [ID_W-1:0]  op_cfg,
    output logic [CNT_W-1:0] stall_cycles,
    output logic [CNT_W-1:0] prefetch_issues
);
    import rpc_pkg::*;

    req_kind_e       kind;
    logic            take;
    logic            take_exec;
    logic            take_pf;
    logic            slot_valid;
    logic [ID_W-1:0] slot_id;
    logic            match;
    logic            idle;
    logic            last;

    // Handshake and request decode.
    always_comb begin
        kind      = req_kind_e'(req_is_prefetch);
        req_ready = !stall;
        take      = req_valid && req_ready;
        take_exec = take && (kind == REQ_EXEC);
        take_pf   = take && (kind == REQ_PREFETCH);
    end

    rpc_slot_tracker #(
        .ID_W  (ID_W),
        .LAT_W (LAT_W)
    ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .lat        (load_latency),
        .take       (take),
        .take_id    (req_cfg),
        .slot_valid (slot_valid),
        .slot_id    (slot_id),
        .match      (match),
        .idle       (idle),
        .last       (last)
    );

    rpc_host_gate #(
        .ID_W (ID_W)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_exec (take_exec),
        .take_id   (req_cfg),
        .match     (match),
        .idle      (idle),
        .last      (last),
        .stall     (stall),
        .done      (op_done),
        .done_id   (op_cfg)
    );

    rpc_sat_counter #(
        .W (CNT_W)
    ) u_stall_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (stall),
        .count (stall_cycles)
    );

    rpc_sat_counter #(
        .W (CNT_W)
    ) u_pf_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (take_pf),
        .count (prefetch_issues)
    );

    AST_DONE_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (slot_valid && (slot_id == op_cfg) && idle)); // R2

    AST_PF_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        take_pf |=> !stall); // R6

    AST_STALL_FREEZES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (slot_id == $past(slot_id))); // R10

endmodule

// File: tb/reconf_prefetch_ctrl_test.sv
// Self-checking bench: vector table walk, then directed corner cases.
module reconf_prefetch_ctrl_test;
    localparam int PERIOD = 10;
    localparam int ID_W   = 4;
    localparam int LAT_W  = 16;
    localparam int CNT_W  = 32;
    localparam int LAT    = 10;
    localparam int NVEC   = 19;

    logic             clk;
    logic             rst_n;
    logic [LAT_W-1:0] load_latency;
    logic             req_valid;
    logic             req_ready;
    logic             req_is_prefetch;
    logic [ID_W-1:0]  req_cfg;
    logic             stall;
    logic             op_done;
    logic [ID_W-1:0]  op_cfg;
    logic [CNT_W-1:0] stall_cycles;
    logic [CNT_W-1:0] prefetch_issues;

    logic             s_ready, s_stall, s_done;
    logic [ID_W-1:0]  s_cfg;
    logic [2:0]       s_stall_cycles, s_pf_issues;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    reconf_prefetch_ctrl #(.ID_W(ID_W), .LAT_W(LAT_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .load_latency(load_latency),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_is_prefetch(req_is_prefetch), .req_cfg(req_cfg),
        .stall(stall), .op_done(op_done), .op_cfg(op_cfg),
        .stall_cycles(stall_cycles), .prefetch_issues(prefetch_issues)
    );

    // Narrow-counter copy driven by the same stimulus, for saturation.
    reconf_prefetch_ctrl #(.ID_W(ID_W), .LAT_W(LAT_W), .CNT_W(3)) uut_sat (
        .clk(clk), .rst_n(rst_n), .load_latency(load_latency),
        .req_valid(req_valid), .req_ready(s_ready),
        .req_is_prefetch(req_is_prefetch), .req_cfg(req_cfg),
        .stall(s_stall), .op_done(s_done), .op_cfg(s_cfg),
        .stall_cycles(s_stall_cycles), .prefetch_issues(s_pf_issues)
    );

    initial clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    // Row: {prefetch, cfg, idle cycles before, expected stall}
    localparam logic [20:0] VEC [0:NVEC-1] = '{
        {1'b0, 4'd3, 8'd0,  8'd10}, // R3 miss into empty slot
        {1'b0, 4'd3, 8'd0,  8'd0 }, // R2 hit
        {1'b0, 4'd3, 8'd0,  8'd0 }, // R4 stays resident
        {1'b1, 4'd5, 8'd0,  8'd0 }, // R6 prefetch starts load
        {1'b0, 4'd5, 8'd3,  8'd6 }, // R7 k=4
        {1'b1, 4'd5, 8'd0,  8'd0 }, // R5 prefetch of resident
        {1'b0, 4'd5, 8'd0,  8'd0 }, // R5 still resident
        {1'b1, 4'd7, 8'd0,  8'd0 }, // R6
        {1'b1, 4'd7, 8'd2,  8'd0 }, // R5 prefetch of loading cfg
        {1'b0, 4'd7, 8'd0,  8'd6 }, // R5 countdown not restarted, k=4
        {1'b1, 4'd2, 8'd0,  8'd0 }, // R6
        {1'b0, 4'd9, 8'd1,  8'd10}, // R8 mismatch discards load
        {1'b0, 4'd9, 8'd0,  8'd0 }, // R2
        {1'b1, 4'd4, 8'd0,  8'd0 }, // R6
        {1'b0, 4'd4, 8'd12, 8'd0 }, // R7 load long finished
        {1'b1, 4'd6, 8'd0,  8'd0 }, // R6
        {1'b0, 4'd6, 8'd8,  8'd1 }, // R7 k=9, one cycle left
        {1'b1, 4'd1, 8'd0,  8'd0 }, // R6
        {1'b0, 4'd1, 8'd9,  8'd0 }  // R7 k=10, finishes same edge
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one request; returns at the negedge after acceptance.
    task automatic issue(input bit pf, input logic [ID_W-1:0] id);
        check(req_ready == 1'b1, "R10 ready before request", int'(req_ready), 1);
        req_valid       = 1'b1;
        req_is_prefetch = pf;
        req_cfg         = id;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (stall) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_exec(input logic [ID_W-1:0] id, input int exp, input string req);
        int n;
        issue(1'b0, id);
        measure(n);
        check(n == exp, req, n, exp);
        check(op_done && (op_cfg == id), {req, " op_done/op_cfg"}, int'(op_cfg), int'(id));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(PERIOD * 50000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_is_prefetch = 1'b0;
        req_cfg = '0;
        load_latency = LAT_W'(LAT);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(!stall && !op_done && req_ready, "R1 reset handshake", int'(stall), 0);
        check(stall_cycles == 0 && prefetch_issues == 0, "R1 reset counters",
              int'(stall_cycles), 0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [20:0] v;
            v = VEC[i];
            repeat (int'(v[15:8])) @(negedge clk);
            if (v[20]) begin
                issue(1'b1, v[19:16]);
                check(!stall && req_ready && !op_done,
                      $sformatf("R5/R6 prefetch row %0d no stall", i), int'(stall), 0);
            end else begin
                run_exec(v[19:16], int'(v[7:0]),
                         $sformatf("R2/R3/R4/R5/R7/R8 row %0d stall", i));
            end
        end

        // R11 counters after the table
        check(stall_cycles == 33, "R11 stall count", int'(stall_cycles), 33);
        check(prefetch_issues == 8, "R11 prefetch count", int'(prefetch_issues), 8);
        check(s_stall_cycles == 3'd7, "R11 stall saturation", int'(s_stall_cycles), 7);
        check(s_pf_issues == 3'd7, "R11 prefetch saturation", int'(s_pf_issues), 7);

        // R10 request held during a stall is not accepted
        req_valid = 1'b1;
        req_is_prefetch = 1'b0;
        req_cfg = 4'd8;
        @(posedge clk);
        @(negedge clk);
        req_is_prefetch = 1'b1;
        req_cfg = 4'd11;
        check(req_ready == 1'b0, "R10 ready low while stalled", int'(req_ready), 0);
        measure(n);
        req_valid = 1'b0;
        check(n == LAT, "R10 stall with pending prefetch", n, LAT);
        check(op_done && op_cfg == 4'd8, "R10 awaited cfg released", int'(op_cfg), 8);
        check(prefetch_issues == 8, "R10 blocked prefetch not counted",
              int'(prefetch_issues), 8);
        run_exec(4'd8, 0, "R10 slot not evicted by blocked prefetch");

        // R9 zero latency treated as one, and sampling at load start
        load_latency = '0;
        run_exec(4'd12, 1, "R9 zero latency");
        load_latency = LAT_W'(20);
        issue(1'b0, 4'd13);
        load_latency = LAT_W'(5);
        measure(n);
        check(n == 20, "R9 latency sampled at start", n, 20);
        load_latency = LAT_W'(LAT);

        // R1 reset clears slot: configuration 0 is not a hit
        do_reset();
        check(!stall && !op_done && req_ready, "R1 second reset", int'(stall), 0);
        check(stall_cycles == 0 && prefetch_issues == 0, "R1 counters cleared",
              int'(prefetch_issues), 0);
        run_exec(4'd0, LAT, "R1 first execute cfg 0 misses");
        run_exec(4'd0, 0, "R4 cfg 0 resident");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule